// File: doc/BRIEF.md
# Byte-Stuffing Octet Frame Encoder

This block turns a stream of packet bytes into a continuous framed octet stream. Packets arrive over a valid/ready interface that has a last marker. Each packet is framed by the flag octet 7Eh. Any payload octet that could be mistaken for a flag or an escape is replaced by a two-octet escape pair. When no packet is in progress, the encoder keeps the line filled with flags. Two packets that follow each other closely share one flag between them.

Both stream edges follow valid/ready rules. An octet moves when valid and ready are both high on a rising clock edge.

- Output side: once out_valid is raised, out_data is held until it is accepted. The one exception is while the line is idle: there out_valid stays high and the filler flag may be replaced by a newly arrived payload octet.
- Input side: an input octet is accepted in the same cycle that its encoded form, or the first octet of its escape pair, leaves on the output. in_ready therefore follows out_ready combinationally. in_ready is forced low while the second octet of an escape pair or a closing flag is sent.
- Upstream must keep in_valid and its data stable until they are accepted.

Top module: `hdlc_octet_framer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block into idle. The first output after reset is the flag 7Eh, with out_valid high and in_ready low.
- R2: A payload octet 7Eh is emitted as 7Dh and then 5Eh in two consecutive output transfers. in_ready is low while 5Eh is presented.
- R3: A payload octet 7Dh is emitted as 7Dh and then 5Dh in two consecutive output transfers. in_ready is low while 5Dh is presented.
- R4: Every payload octet other than 7Dh and 7Eh is emitted unchanged, in the same cycle it is accepted. Accepting a payload octet never presents 7Eh on out_data.
- R5: While no packet is open and in_valid is low, out_valid is high and out_data is 7Eh on every cycle.
- R6: After the octet accepted with in_last (or after the second octet of its escape pair), exactly one 7Eh is emitted, with in_ready low. A following packet whose first octet is already waiting is emitted in the very next transfer, so both packets share that single flag.
- R7: When a packet starts from idle, its first octet replaces the idle flag directly, with no extra flag inserted. It is emitted and accepted in the cycle in_valid rises (given out_ready).
- R8: While out_ready is low, no input octet is accepted: in_ready is low and the state does not advance. in_ready is never high unless out_ready is high.
- R9: While a packet is open (its last octet not yet accepted) and in_valid is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Payload octet |
| in_valid | input | 1 | Payload octet is present |
| in_last | input | 1 | Payload octet ends its packet |
| in_ready | output | 1 | Payload octet is taken this cycle if in_valid is high |
| out_data | output | 8 | Encoded line octet |
| out_valid | output | 1 | out_data is meaningful |
| out_ready | input | 1 | Downstream takes out_data this cycle |

## Verification
Two functions can meet in one output cycle: the closing flag of one packet and the opening of the next, and also the idle flag fill and the arrival of a packet's first octet. The bench provokes both cases by holding in_valid high across a packet boundary, and by raising in_valid while flags are streaming. Both cases are also exercised under random out_ready gaps. It judges them by walking every output transfer against an arithmetically built expected octet list. In that walk, a 7Eh that is not in the list is accepted only at a packet boundary. Directed cycle checks also require that the octet after the shared flag is the next packet's first octet.

// File: rtl/hdlc_enc_pkg.sv
package hdlc_enc_pkg;

  // Framer control states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // last octet sent was a flag, no packet open
    ST_OPEN  = 2'd1,  // inside a packet, more payload expected
    ST_ESC   = 2'd2,  // second octet of an escape pair is pending
    ST_CLOSE = 2'd3   // closing (or post-reset) flag is pending
  } fr_state_e;

endpackage

// File: rtl/hdlc_esc_map.sv
module hdlc_esc_map #(
  parameter int            DATA_W = 8,
  parameter logic [DATA_W-1:0] FLAG_B = 8'h7E,
  parameter logic [DATA_W-1:0] ESC_B  = 8'h7D,
  parameter logic [DATA_W-1:0] MASK_B = 8'h20
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              special_o,
  output logic [DATA_W-1:0] pair_o
);

  // Reserved values are escaped; the second octet is the value with the mask flipped.
  always_comb begin
    special_o = (byte_i == FLAG_B) || (byte_i == ESC_B);
    pair_o    = byte_i ^ MASK_B;
  end

endmodule

// File: rtl/hdlc_frame_ctrl.sv
module hdlc_frame_ctrl
  import hdlc_enc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_ready,
  input  logic              out_valid,
  input  logic              out_ready,
  input  logic              special_i,
  input  logic [DATA_W-1:0] pair_i,
  output fr_state_e         state_o,
  output logic [DATA_W-1:0] esc_q_o
);

  fr_state_e         st_q, st_d;
  logic [DATA_W-1:0] esc_q, esc_d;
  logic              esc_last_q, esc_last_d;
  logic              take, fire;

  assign take = in_valid & in_ready;
  assign fire = out_valid & out_ready;

  always_comb begin
    st_d       = st_q;
    esc_d      = esc_q;
    esc_last_d = esc_last_q;
    unique case (st_q)
      ST_IDLE, ST_OPEN: begin
        if (take) begin
          if (special_i) begin
            st_d       = ST_ESC;
            esc_d      = pair_i;
            esc_last_d = in_last;
          end else if (in_last) begin
            st_d = ST_CLOSE;
          end else begin
            st_d = ST_OPEN;
          end
        end
      end
      ST_ESC: begin
        if (fire) st_d = esc_last_q ? ST_CLOSE : ST_OPEN;
      end
      ST_CLOSE: begin
        if (fire) st_d = ST_IDLE;
      end
      default: st_d = ST_CLOSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_CLOSE;
      esc_q      <= '0;
      esc_last_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      esc_q      <= esc_d;
      esc_last_q <= esc_last_d;
    end
  end

  assign state_o = st_q;
  assign esc_q_o = esc_q;

endmodule

// File: rtl/hdlc_out_mux.sv
module hdlc_out_mux
  import hdlc_enc_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] FLAG_B = 8'h7E,
  parameter logic [DATA_W-1:0] ESC_B  = 8'h7D
) (
  input  fr_state_e         state_i,
  input  logic [DATA_W-1:0] esc_q_i,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              special_i,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              in_ready
);

  logic [DATA_W-1:0] pay_byte;

  assign pay_byte = special_i ? ESC_B : in_data;

  always_comb begin
    out_data  = FLAG_B;
    out_valid = 1'b1;
    in_ready  = 1'b0;
    unique case (state_i)
      ST_CLOSE: begin
        out_data = FLAG_B;
      end
      ST_ESC: begin
        out_data = esc_q_i;
      end
      ST_IDLE: begin
        in_ready = out_ready;
        out_data = in_valid ? pay_byte : FLAG_B;
      end
      ST_OPEN: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_valid ? pay_byte : FLAG_B;
      end
      default: begin
        out_data = FLAG_B;
      end
    endcase
  end

endmodule

// File: rtl/hdlc_octet_framer.sv
module hdlc_octet_framer
  import hdlc_enc_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] FLAG_B = 8'h7E,
  parameter logic [DATA_W-1:0] ESC_B  = 8'h7D,
  parameter logic [DATA_W-1:0] MASK_B = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  logic              special;
  logic [DATA_W-1:0] pair;
  fr_state_e         state;
  logic [DATA_W-1:0] esc_q;

  hdlc_esc_map #(
    .DATA_W(DATA_W), .FLAG_B(FLAG_B), .ESC_B(ESC_B), .MASK_B(MASK_B)
  ) u_map (
    .byte_i   (in_data),
    .special_o(special),
    .pair_o   (pair)
  );

  hdlc_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .special_i(special),
    .pair_i   (pair),
    .state_o  (state),
    .esc_q_o  (esc_q)
  );

  hdlc_out_mux #(
    .DATA_W(DATA_W), .FLAG_B(FLAG_B), .ESC_B(ESC_B)
  ) u_mux (
    .state_i  (state),
    .esc_q_i  (esc_q),
    .in_data  (in_data),
    .in_valid (in_valid),
    .special_i(special),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .in_ready (in_ready)
  );

endmodule

// File: rtl/hdlc_framer_chk.sv
module hdlc_framer_chk #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] FLAG_B = 8'h7E,
  parameter logic [DATA_W-1:0] ESC_B  = 8'h7D,
  parameter logic [DATA_W-1:0] MASK_B = 8'h20
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready
);

  // R8: input is only taken when the output side is taking too
  p_ready_gated_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> out_ready);

  // R4: accepting payload never puts a flag on the line
  p_take_not_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (out_valid && out_data != FLAG_B));

  // R2: an escape octet transfer is followed by a valid second octet, input stalled
  p_esc_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_data == ESC_B) |=>
      (out_valid && !in_ready &&
       (out_data == (FLAG_B ^ MASK_B) || out_data == (ESC_B ^ MASK_B))));

  // R3: an accepted escape-valued payload yields the matching second octet
  p_esc_value_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_data == ESC_B) |=> (out_data == (ESC_B ^ MASK_B)));

  // R6: a plain last octet is followed by one closing flag with input stalled
  p_close_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last && out_data != ESC_B) |=>
      (out_valid && out_data == FLAG_B && !in_ready));

endmodule

bind hdlc_octet_framer hdlc_framer_chk #(
  .DATA_W(DATA_W), .FLAG_B(FLAG_B), .ESC_B(ESC_B), .MASK_B(MASK_B)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_data  (in_data),
  .in_valid (in_valid),
  .in_last  (in_last),
  .in_ready (in_ready),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_ready(out_ready)
);

// File: tb/sim_hdlc_octet_framer.sv
`timescale 1ns/1ps
module sim_hdlc_octet_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready;
  logic       rdy_rand = 1'b0;
  logic       rdy_force = 1'b1;
  logic       rnd_bit = 1'b1;

  always #2.5 clk = ~clk;

  assign out_ready = rdy_rand ? rnd_bit : rdy_force;
  always @(posedge clk) begin
    #1 rnd_bit = ($urandom % 10) < 7;
  end

  hdlc_octet_framer u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected octet list built from the requirements
  logic [7:0] eq [0:16383];
  string      et [0:16383];
  int         wp = 0;
  int         rp = 0;
  bit         at_bnd = 1'b1;

  task automatic push(logic [7:0] b, string t);
    eq[wp] = b; et[wp] = t; wp++;
  endtask

  task automatic enq_byte(logic [7:0] b, bit last);
    if (b == 8'h7E) begin push(8'h7D, "R2"); push(8'h5E, "R2"); end
    else if (b == 8'h7D) begin push(8'h7D, "R3"); push(8'h5D, "R3"); end
    else push(b, "R4");
    if (last) push(8'h7E, "R6");
  endtask

  // Stream monitor: every output transfer is judged
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (rp != wp && out_data == eq[rp]) begin
        chk(1'b1, et[rp], out_data, eq[rp]);
        at_bnd = (out_data == 8'h7E);
        rp++;
      end else if (out_data == 8'h7E && at_bnd) begin
        chk(1'b1, "R5", out_data, 8'h7E);
      end else begin
        chk(1'b0, (rp != wp) ? et[rp] : "R5", out_data, (rp != wp) ? eq[rp] : 8'h7E);
        if (rp != wp) rp++;
      end
    end
  end

  task automatic send(logic [7:0] b, bit last, int gap);
    bit f;
    if (gap > 0) begin
      in_valid = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
    enq_byte(b, last);
    in_data = b; in_last = last; in_valid = 1'b1;
    do begin
      @(negedge clk); f = in_ready;
      @(posedge clk); #1;
    end while (!f);
    in_valid = 1'b0;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid, "R1", {7'd0, out_valid}, 8'h01);
    chk(out_data == 8'h7E, "R1", out_data, 8'h7E);
    chk(!in_ready, "R1", {7'd0, in_ready}, 8'h00);
    // R5: idle fill
    for (int i = 0; i < 4; i++) begin
      step(); @(negedge clk);
      chk(out_valid && out_data == 8'h7E, "R5", out_data, 8'h7E);
    end
    // R7: first octet replaces idle flag; then an escaped last octet
    step();
    enq_byte(8'h41, 1'b0);
    in_data = 8'h41; in_last = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk(out_data == 8'h41, "R7", out_data, 8'h41);
    chk(in_ready, "R7", {7'd0, in_ready}, 8'h01);
    step();
    enq_byte(8'h7E, 1'b1);
    in_data = 8'h7E; in_last = 1'b1;
    @(negedge clk);
    chk(out_data == 8'h7D, "R2", out_data, 8'h7D);
    step(); in_valid = 1'b0;
    @(negedge clk);
    chk(out_data == 8'h5E, "R2", out_data, 8'h5E);
    chk(!in_ready, "R2", {7'd0, in_ready}, 8'h00);
    step(); @(negedge clk);
    chk(out_data == 8'h7E && !in_ready, "R6", out_data, 8'h7E);
    step(); @(negedge clk);
    chk(out_valid && out_data == 8'h7E && in_ready, "R5", out_data, 8'h7E);
    // R9: starvation inside a packet
    step();
    send(8'h10, 1'b0, 0);
    @(negedge clk);
    chk(!out_valid, "R9", {7'd0, out_valid}, 8'h00);
    step();
    @(negedge clk);
    chk(!out_valid, "R9", {7'd0, out_valid}, 8'h00);
    step();
    send(8'h11, 1'b1, 0);
    repeat (3) step();
    // R6: back-to-back packets share one flag
    enq_byte(8'h01, 1'b1); enq_byte(8'h02, 1'b1);
    in_data = 8'h01; in_last = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk(out_data == 8'h01, "R6", out_data, 8'h01);
    step(); in_data = 8'h02;
    @(negedge clk);
    chk(out_data == 8'h7E && !in_ready, "R6", out_data, 8'h7E);
    step(); @(negedge clk);
    chk(out_data == 8'h02 && in_ready, "R6", out_data, 8'h02);
    step(); in_valid = 1'b0;
    repeat (2) step();
    // R8: backpressure holds input
    rdy_force = 1'b0;
    enq_byte(8'h7D, 1'b1);
    in_data = 8'h7D; in_last = 1'b1; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!in_ready, "R8", {7'd0, in_ready}, 8'h00);
      chk(out_data == 8'h7D, "R8", out_data, 8'h7D);
      step();
    end
    rdy_force = 1'b1;
    @(negedge clk);
    chk(in_ready, "R8", {7'd0, in_ready}, 8'h01);
    step(); in_valid = 1'b0;
    @(negedge clk);
    chk(out_data == 8'h5D && !in_ready, "R3", out_data, 8'h5D);
    repeat (3) step();
    // Sweep: every octet value as a one-octet packet, random out_ready
    rdy_rand = 1'b1;
    for (int v = 0; v < 256; v++) send(v[7:0], 1'b1, $urandom % 3);
    // Multi-octet packets biased toward reserved values
    for (int p = 0; p < 40; p++) begin
      int len;
      len = 1 + ($urandom % 16);
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        int r;
        r = $urandom % 4;
        b = (r == 0) ? 8'h7E : (r == 1) ? 8'h7D : 8'($urandom);
        send(b, i == len - 1, (p % 3 == 0) ? ($urandom % 2) : 0);
      end
    end
    rdy_rand = 1'b0; rdy_force = 1'b1;
    repeat (20) step();
    chk(rp == wp, "R6", 8'(wp - rp), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule